// File: doc/BRIEF.md
# SD Block Gap Stop Controller

This block is the block-gap control logic of an SD/SDIO host controller during multi-block transfers. Software writes an 8-bit control word over a simple single-register bus. The word can ask the transfer to pause at the next block boundary, restart a paused transfer, pick how incoming read data is held while paused, and enable interrupt sampling in the gap between blocks.

The data path reports each block boundary, the end of the transfer, its direction and its bus width, and the two activity flags: data line active for reads and write transfer active for writes. From these the block drives a pause request. For reads it also drives either a read-wait request on DAT[2] or a card clock stop, and it blocks command generation while the clock is stopped. It also drives an interrupt-sample window and a flag that reports when suspend/resume is not available.

Top module: `sdgap_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, pause, read-wait, clock-stop, command-block and interrupt-sample outputs are 0, and the suspend-unsupported flag is 1.
- R2: The control word has bit 0 = stop request, bit 1 = continue request, bit 2 = read-wait enable, bit 3 = gap interrupt enable. Bits 0, 2 and 3 take the written value on a write. Bits 7:4 always read as 0.
- R3: While bit 0 of the stored word is 1, a write leaves bit 1 unchanged.
- R4: With bit 0 clear, writing 1 to bit 1 sets it. Writing 0 to bit 1 never clears it.
- R5: In a read transfer, bit 1 clears on the cycle after the data-line-active input rises. A rise of write-transfer-active does not clear it.
- R6: In a write transfer, bit 1 clears on the cycle after write-transfer-active rises. A rise of data-line-active does not clear it.
- R7: A stop request takes effect only at a block boundary pulse. The pause output rises in the cycle after that pulse and never without one.
- R8: A pause ends only once the stored word has bit 0 = 0 and bit 1 = 1, one cycle after that state is reached. While bit 0 stays 1 the pause holds.
- R9: In a paused read with read-wait enabled, the read-wait output is 1 and the clock stays running.
- R10: In a paused read with read-wait disabled, the clock-stop and command-block outputs are 1 and read-wait is 0. A paused write asserts none of the three.
- R11: The interrupt-sample output is 1 only when bit 3 is set, 4-bit mode is selected, the transfer is multi-block and the data path sits between blocks (after a boundary pulse and before the next activity rise in the current direction).
- R12: A transfer-done pulse ends any pause and the between-blocks state on the next cycle, which releases read-wait and the clock stop.
- R13: The suspend-unsupported output equals the inverse of bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Stored control word |
| xfer_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| multi_blk | input | 1 | Transfer is multi-block |
| bus_4bit | input | 1 | 4-bit data bus mode |
| dat_active | input | 1 | Data line active status |
| wr_active | input | 1 | Write transfer active status |
| blk_end | input | 1 | One-cycle pulse at each block boundary |
| xfer_done | input | 1 | One-cycle pulse at transfer completion |
| pause | output | 1 | Transfer paused at block gap |
| rdwait_drv | output | 1 | Request to signal read wait on DAT[2] |
| sdclk_stop | output | 1 | Stop the card clock |
| cmd_block | output | 1 | Command generation blocked |
| int_sample_en | output | 1 | Sample card interrupt now |
| susp_unsupported | output | 1 | Suspend/resume not available |

## Verification
A wrong pause state shows at the pause output and at the read-wait or clock-stop output one cycle after the boundary or release that should have changed it. Missing or extra clearing of the continue bit is visible on the read-back port one cycle after the activity edge or the write. A stale between-blocks flag shows as an interrupt-sample window that stays open after activity restarts or after transfer done, again one cycle later. The bench therefore checks every port after each clock.

// File: rtl/sdgap_pkg.sv
package sdgap_pkg;
    localparam int CTL_W      = 8;
    localparam int BIT_STOP   = 0;
    localparam int BIT_CONT   = 1;
    localparam int BIT_RDWAIT = 2;
    localparam int BIT_IRQGAP = 3;
    localparam int NUM_ACT    = 2;
    localparam int ACT_RD     = 0;
    localparam int ACT_WR     = 1;

    typedef struct packed {
        logic irq_gap_en;
        logic rdwait_en;
        logic cont_req;
        logic stop_req;
    } ctl_t;

    typedef struct packed {
        logic paused;
        logic in_gap;
    } hold_t;
endpackage

// File: rtl/sdgap_edge.sv
module sdgap_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/sdgap_ctlreg.sv
module sdgap_ctlreg
    import sdgap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             restart_seen,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rd_data
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (restart_seen) ctl_d.cont_req = 1'b0;
        if (wr_en) begin
            ctl_d.stop_req   = wr_data[BIT_STOP];
            ctl_d.rdwait_en  = wr_data[BIT_RDWAIT];
            ctl_d.irq_gap_en = wr_data[BIT_IRQGAP];
            if (!ctl_q.stop_req && wr_data[BIT_CONT]) ctl_d.cont_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data             = '0;
        rd_data[BIT_STOP]   = ctl_q.stop_req;
        rd_data[BIT_CONT]   = ctl_q.cont_req;
        rd_data[BIT_RDWAIT] = ctl_q.rdwait_en;
        rd_data[BIT_IRQGAP] = ctl_q.irq_gap_en;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/sdgap_hold.sv
module sdgap_hold
    import sdgap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    input  logic blk_end,
    input  logic xfer_done,
    input  logic restart_seen,
    input  logic xfer_rd,
    input  logic multi_blk,
    input  logic bus_4bit,
    output logic pause,
    output logic rdwait_drv,
    output logic sdclk_stop,
    output logic int_sample_en
);
    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (blk_end) begin
            st_d.in_gap = 1'b1;
            if (ctl.stop_req) st_d.paused = 1'b1;
        end else if (st_q.paused && !ctl.stop_req && ctl.cont_req) begin
            st_d.paused = 1'b0;
        end
        if (restart_seen) st_d.in_gap = 1'b0;
        if (xfer_done) begin
            st_d.paused = 1'b0;
            st_d.in_gap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pause         = st_q.paused;
        rdwait_drv    = st_q.paused & xfer_rd & ctl.rdwait_en;
        sdclk_stop    = st_q.paused & xfer_rd & ~ctl.rdwait_en;
        int_sample_en = ctl.irq_gap_en & bus_4bit & multi_blk & st_q.in_gap;
    end
endmodule

// File: rtl/sdgap_ctrl.sv
module sdgap_ctrl
    import sdgap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic [CTL_W-1:0] cfg_rdata,
    input  logic             xfer_rd,
    input  logic             multi_blk,
    input  logic             bus_4bit,
    input  logic             dat_active,
    input  logic             wr_active,
    input  logic             blk_end,
    input  logic             xfer_done,
    output logic             pause,
    output logic             rdwait_drv,
    output logic             sdclk_stop,
    output logic             cmd_block,
    output logic             int_sample_en,
    output logic             susp_unsupported
);
    logic [NUM_ACT-1:0] act_lvl, act_rise;
    logic               restart_seen;
    ctl_t               ctl;

    always_comb begin
        act_lvl         = '0;
        act_lvl[ACT_RD] = dat_active;
        act_lvl[ACT_WR] = wr_active;
    end

    sdgap_edge #(.N(NUM_ACT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (act_lvl),
        .rise  (act_rise)
    );

    assign restart_seen = xfer_rd ? act_rise[ACT_RD] : act_rise[ACT_WR];

    sdgap_ctlreg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_data      (cfg_wdata),
        .restart_seen (restart_seen),
        .ctl          (ctl),
        .rd_data      (cfg_rdata)
    );

    sdgap_hold u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl           (ctl),
        .blk_end       (blk_end),
        .xfer_done     (xfer_done),
        .restart_seen  (restart_seen),
        .xfer_rd       (xfer_rd),
        .multi_blk     (multi_blk),
        .bus_4bit      (bus_4bit),
        .pause         (pause),
        .rdwait_drv    (rdwait_drv),
        .sdclk_stop    (sdclk_stop),
        .int_sample_en (int_sample_en)
    );

    assign cmd_block        = sdclk_stop;
    assign susp_unsupported = ~ctl.rdwait_en;
endmodule

// File: rtl/sdgap_chk.sv
module sdgap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic       xfer_rd,
    input logic       multi_blk,
    input logic       bus_4bit,
    input logic       dat_active,
    input logic       blk_end,
    input logic       xfer_done,
    input logic       pause,
    input logic       rdwait_drv,
    input logic       sdclk_stop,
    input logic       int_sample_en
);
    // R3: continue bit cannot be set by a write while stop is stored
    a_r3_cont_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_rdata[0] && !cfg_rdata[1] |=> !cfg_rdata[1]);

    // R5: read restart clears continue
    a_r5_rd_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rd && $rose(dat_active) && !cfg_we |=> !cfg_rdata[1]);

    // R7: pause never starts without a boundary
    a_r7_no_mid_block: assert property (@(posedge clk) disable iff (!rst_n)
        !pause && !blk_end |=> !pause);

    // R7: pause follows a boundary with stop requested
    a_r7_pause_at_gap: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end && cfg_rdata[0] && !xfer_done |=> pause);

    // R8: pause holds while stop stays requested
    a_r8_hold_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        pause && cfg_rdata[0] && !xfer_done |=> pause);

    // R9: read wait and clock stop never together
    a_r9_hold_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdwait_drv && sdclk_stop));

    // R11: sampling window needs all enables
    a_r11_int_window: assert property (@(posedge clk) disable iff (!rst_n)
        int_sample_en |-> bus_4bit && multi_blk && cfg_rdata[3]);

    // R12: done releases everything
    a_r12_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !pause && !rdwait_drv && !sdclk_stop);
endmodule

bind sdgap_ctrl sdgap_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_rdata     (cfg_rdata),
    .xfer_rd       (xfer_rd),
    .multi_blk     (multi_blk),
    .bus_4bit      (bus_4bit),
    .dat_active    (dat_active),
    .blk_end       (blk_end),
    .xfer_done     (xfer_done),
    .pause         (pause),
    .rdwait_drv    (rdwait_drv),
    .sdclk_stop    (sdclk_stop),
    .int_sample_en (int_sample_en)
);

// File: tb/tb_sdgap_ctrl.sv
`timescale 1ns/1ps
module tb_sdgap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       xfer_rd = 1'b0, multi_blk = 1'b0, bus_4bit = 1'b0;
    logic       dat_active = 1'b0, wr_active = 1'b0;
    logic       blk_end = 1'b0, xfer_done = 1'b0;
    logic       pause, rdwait_drv, sdclk_stop, cmd_block, int_sample_en, susp_unsupported;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [13:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    sdgap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_rd(xfer_rd), .multi_blk(multi_blk),
        .bus_4bit(bus_4bit), .dat_active(dat_active), .wr_active(wr_active),
        .blk_end(blk_end), .xfer_done(xfer_done), .pause(pause),
        .rdwait_drv(rdwait_drv), .sdclk_stop(sdclk_stop), .cmd_block(cmd_block),
        .int_sample_en(int_sample_en), .susp_unsupported(susp_unsupported)
    );

    // expected vector: {rdata, pause, rdwait, clkstop, cmdblock, intsample, susp}
    function automatic logic [13:0] ex(input logic [7:0] rd, input logic p, input logic rw,
                                       input logic cs, input logic is, input logic su);
        return {rd, p, rw, cs, cs, is, su};
    endfunction

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [13:0] act;
            e = sb.pop_front();
            act = {cfg_rdata, pause, rdwait_drv, sdclk_stop, cmd_block, int_sample_en, susp_unsupported};
            checks++;
            if (act !== e.val) begin
                failures++;
                $display("FAIL %s: actual=%b expected=%b", e.tag, act, e.val);
            end
        end
    end

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic we, input logic [7:0] wd, input logic bnd,
                        input logic done, input logic [13:0] e, input string tag);
        exp_t item;
        cfg_we = we; cfg_wdata = wd; blk_end = bnd; xfer_done = done;
        @(posedge clk);
        #2;
        item.val = e;
        item.tag = tag;
        sb.push_back(item);
        @(negedge clk);
        #1;
        cfg_we = 1'b0; blk_end = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic idle(input logic [13:0] e, input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, e, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;

        idle(ex(8'h00,0,0,0,0,1), "R1 reset state");
        step(1, 8'hF4, 0, 0, ex(8'h04,0,0,0,0,0), "R2 reserved read zero");
        step(1, 8'hFD, 0, 0, ex(8'h0D,0,0,0,0,0), "R2 bits 3 2 0 stored");
        step(1, 8'h0F, 0, 0, ex(8'h0D,0,0,0,0,0), "R3 continue ignored under stop");

        xfer_rd = 1; multi_blk = 1; bus_4bit = 1;
        idle(ex(8'h0D,0,0,0,0,0), "R7 no pause without boundary");
        step(0, 8'h00, 1, 0, ex(8'h0D,1,1,0,1,0), "R7 R9 R11 pause at boundary, read wait");
        bus_4bit = 0;
        idle(ex(8'h0D,1,1,0,0,0), "R11 window closed in 1-bit mode");
        bus_4bit = 1;
        step(1, 8'h0E, 0, 0, ex(8'h0C,1,1,0,1,0), "R8 continue ignored in same write as stop clear");
        step(1, 8'h0E, 0, 0, ex(8'h0E,1,1,0,1,0), "R8 continue set, pause still held");
        idle(ex(8'h0E,0,0,0,1,0), "R8 pause released");
        wr_active = 1;
        idle(ex(8'h0E,0,0,0,1,0), "R5 write active rise ignored in read");
        dat_active = 1;
        idle(ex(8'h0C,0,0,0,0,0), "R5 R11 read restart clears continue and gap");

        dat_active = 0;
        step(1, 8'h09, 0, 0, ex(8'h09,0,0,0,0,1), "R13 suspend unsupported");
        step(0, 8'h00, 1, 0, ex(8'h09,1,0,1,1,1), "R10 clock stop when read wait off");
        step(0, 8'h00, 0, 1, ex(8'h09,0,0,0,0,1), "R12 done releases hold");

        xfer_rd = 0;
        step(1, 8'h08, 0, 0, ex(8'h08,0,0,0,0,1), "R2 stop cleared");
        step(1, 8'h0A, 0, 0, ex(8'h0A,0,0,0,0,1), "R4 continue set");
        step(1, 8'h08, 0, 0, ex(8'h0A,0,0,0,0,1), "R4 writing zero keeps continue");
        dat_active = 1;
        idle(ex(8'h0A,0,0,0,0,1), "R6 data active rise ignored in write");
        wr_active = 0;
        idle(ex(8'h0A,0,0,0,0,1), "R6 write active fall no effect");
        wr_active = 1;
        idle(ex(8'h08,0,0,0,0,1), "R6 write restart clears continue");

        step(1, 8'h01, 0, 0, ex(8'h01,0,0,0,0,1), "R7 stop requested mid block");
        idle(ex(8'h01,0,0,0,0,1), "R7 still running mid block");
        step(0, 8'h00, 1, 0, ex(8'h01,1,0,0,0,1), "R10 write pause has no read hold");
        step(0, 8'h00, 0, 1, ex(8'h01,0,0,0,0,1), "R12 done ends write pause");

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule